// File: doc/BRIEF.md
# MMC Boot Block Read Sequencer

This block is a hardware boot loader for an MMC card. It needs no processor. After a start pulse it drives a simple command/response host controller. It resets that controller and sets up its transfer options. It then takes the card through identification and selection with a fixed command script, and copies a run of 512-byte blocks into memory one 32-bit word at a time. When the run is over it raises done or error and holds that flag until the next start pulse.

The controller is reached through these signals:
- a cycle that clears the interrupt-status vector;
- a command issue strobe that carries the command word and its argument;
- the interrupt-status vector with a write-back path;
- response word 0;
- a data-word read port that returns one word for each read strobe.

The sequencer waits on two status bits: bit 16 (command complete) and bit 20 (data ready). Each wait is a bounded poll, and the bound is set by a parameter. The memory write port starts at a base address and moves up by one word for each data word written.

Top module: `mmc_boot_loader`

## Requirements
- R1: After reset, done, error, cmd_start, sts_wr, dat_rd, mem_we, cfg_soft_rst and cfg_clk_en are all 0.
- R2: A start pulse, accepted when idle or finished, gives exactly one cfg_soft_rst cycle. From then on cfg_byte_swap=1, cfg_clk_en=1 and cfg_blk_size=512. The divider code cfg_clk_div is 7 (the /256 rate) for the first command.
- R3: Every command takes two cycles. The first writes 0 to the status vector (sts_wr=1, sts_wdata=0). The next asserts cmd_start with cmd_word and cmd_arg.
- R4: Identification issues, in this order: 0x00000040 with arg 0, then 0x01405040 with arg 0x40300000, then 0x02806040 with arg 0, then 0x03400040 with arg 0x00010000.
- R5: Command 0x01405040 is issued again after each completion whose resp0 bit 31 is 0. Identification goes on after the first completion whose resp0 bit 31 is 1.
- R6: Every command after identification is issued with cfg_clk_div=1 (the /4 rate). Those commands are, in order: 0x09806000 arg 0x00010000, then 0x07400000 arg 0x00010000, then 0x10400000 arg 512.
- R7: Each block starts with command 0x0d400000, arg 0x00010000. If resp0 is not 0x00000900 when that command completes, the run ends with error and no read command follows.
- R8: Block k of the run (k from 0) is read with command 0x11480000, arg (first_blk+k)*512. After status bit 20, 128 words are read. Each word goes to mem_addr = mem_base + 128*k + word index, in rising order.
- R9: When a wait sees its bit (16 for a command, 20 for data), the status vector is written back in the same cycle with only that bit cleared.
- R10: A wait ends after POLL_LIMIT polls without its bit. A command-complete timeout lets the script go on. A data-ready timeout ends the run with error and writes nothing for that block.
- R11: After the last block's words, done goes to 1. With blk_cnt=0, done goes to 1 right after the block-size command. done and error are never both 1, and they hold until the next start pulse clears both.
- R12: A failing block stops the run: no command and no memory write follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse |
| first_blk | input | 32 | First card block number |
| blk_cnt | input | BCW | Number of blocks to copy |
| mem_base | input | AW | First memory word address |
| cfg_soft_rst | output | 1 | Controller soft reset pulse |
| cfg_byte_swap | output | 1 | Byte-swap mode for the data buffer |
| cfg_blk_size | output | 16 | Block size in bytes given to the controller |
| cfg_clk_div | output | 4 | Card clock divider code (7: /256, 1: /4) |
| cfg_clk_en | output | 1 | Card clock enable |
| cmd_start | output | 1 | Command issue strobe |
| cmd_word | output | 32 | Command word |
| cmd_arg | output | 32 | Command argument |
| sts_in | input | 32 | Interrupt status vector |
| sts_wr | output | 1 | Status vector write strobe |
| sts_wdata | output | 32 | Status vector write value |
| resp0 | input | 32 | Response word 0 |
| dat_rd | output | 1 | Data word read strobe |
| dat_in | input | 32 | Data word, valid while dat_rd is high |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| done | output | 1 | Run completed |
| error | output | 1 | Run aborted |

## Verification
The assertions take two things for granted about the controller side. First, resp0 is settled by the time status bit 16 is seen. Second, dat_in is valid in the same cycle as dat_rd. The bench responder sets resp0 when a command is issued, three cycles before it raises bit 16. It computes dat_in combinationally from its word counter. The responder also sets a second status bit next to each completion bit, so a clear that does not mask off only one bit shows up. The start pulse is only driven when the block is idle or finished, and stays one cycle wide.

// File: rtl/mmc_boot_pkg.sv
package mmc_boot_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_INIT, ST_CLR, ST_ISSUE, ST_WCMD, ST_NEXT, ST_WDAT, ST_DATA, ST_FIN
  } seq_state_t;

  typedef enum logic [3:0] {
    STEP_GO_IDLE, STEP_OP_COND, STEP_ALL_CID, STEP_SET_RCA,
    STEP_GET_CSD, STEP_SELECT, STEP_BLKLEN, STEP_STATUS, STEP_READ
  } step_t;

  localparam int          BIT_CMD_DONE = 16;
  localparam int          BIT_DATA_RDY = 20;
  localparam logic [31:0] ADDR_ARG     = 32'h0001_0000;
  localparam logic [31:0] OCR_ARG      = 32'h4030_0000;
  localparam logic [31:0] STATUS_OK    = 32'h0000_0900;
  localparam logic [3:0]  DIV_SLOW     = 4'd7;
  localparam logic [3:0]  DIV_FAST     = 4'd1;

  function automatic logic [31:0] step_word(step_t s);
    case (s)
      STEP_GO_IDLE: return 32'h0000_0040;
      STEP_OP_COND: return 32'h0140_5040;
      STEP_ALL_CID: return 32'h0280_6040;
      STEP_SET_RCA: return 32'h0340_0040;
      STEP_GET_CSD: return 32'h0980_6000;
      STEP_SELECT:  return 32'h0740_0000;
      STEP_BLKLEN:  return 32'h1040_0000;
      STEP_STATUS:  return 32'h0d40_0000;
      STEP_READ:    return 32'h1148_0000;
      default:      return 32'h0000_0000;
    endcase
  endfunction

endpackage

// File: rtl/mmc_boot_rstsync.sv
module mmc_boot_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/mmc_boot_poll.sv
module mmc_boot_poll #(
  parameter int LIMIT = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic hit,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign expired = active && !hit && (cnt_q == CW'(LIMIT - 1));

  always_comb begin
    cnt_d = active ? cnt_q + CW'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/mmc_boot_xfer.sv
module mmc_boot_xfer #(
  parameter int AW    = 16,
  parameter int BCW   = 16,
  parameter int WORDS = 128
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [31:0]    first_blk,
  input  logic [BCW-1:0] blk_cnt,
  input  logic [AW-1:0]  base,
  input  logic           adv,
  output logic [31:0]    blk_num,
  output logic [AW-1:0]  addr,
  output logic           last_word,
  output logic           last_blk,
  output logic           none_left
);
  localparam int WW = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [31:0]    blk_q;
  logic [BCW-1:0] left_q;
  logic [AW-1:0]  addr_q;
  logic [WW-1:0]  word_q;

  assign last_word = (word_q == WW'(WORDS - 1));
  assign last_blk  = (left_q == BCW'(1));
  assign none_left = (left_q == '0);
  assign blk_num   = blk_q;
  assign addr      = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q  <= '0;
      left_q <= '0;
      addr_q <= '0;
      word_q <= '0;
    end else if (load) begin
      blk_q  <= first_blk;
      left_q <= blk_cnt;
      addr_q <= base;
      word_q <= '0;
    end else if (adv) begin
      addr_q <= addr_q + AW'(1);
      if (last_word) begin
        word_q <= '0;
        blk_q  <= blk_q + 32'd1;
        left_q <= left_q - BCW'(1);
      end else begin
        word_q <= word_q + WW'(1);
      end
    end
  end
endmodule

// File: rtl/mmc_boot_loader.sv
module mmc_boot_loader
  import mmc_boot_pkg::*;
#(
  parameter int AW         = 16,
  parameter int BCW        = 16,
  parameter int BLK_BYTES  = 512,
  parameter int POLL_LIMIT = 1000000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [31:0]    first_blk,
  input  logic [BCW-1:0] blk_cnt,
  input  logic [AW-1:0]  mem_base,
  output logic           cfg_soft_rst,
  output logic           cfg_byte_swap,
  output logic [15:0]    cfg_blk_size,
  output logic [3:0]     cfg_clk_div,
  output logic           cfg_clk_en,
  output logic           cmd_start,
  output logic [31:0]    cmd_word,
  output logic [31:0]    cmd_arg,
  input  logic [31:0]    sts_in,
  output logic           sts_wr,
  output logic [31:0]    sts_wdata,
  input  logic [31:0]    resp0,
  output logic           dat_rd,
  input  logic [31:0]    dat_in,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [31:0]    mem_wdata,
  output logic           done,
  output logic           error
);
  localparam int WORDS = BLK_BYTES / 4;
  localparam int SHIFT = $clog2(BLK_BYTES);

  logic       rst_i_n;
  seq_state_t st_q, st_d;
  step_t      step_q, step_d;
  logic       done_q, err_q, set_done, set_err;
  logic       cfg_on_q, fast_q, fast_set;
  logic       accept, waiting, hit, tmo;
  logic [31:0] bit_mask, blk_num;
  logic       last_word, last_blk, none_left;

  mmc_boot_rstsync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  assign accept   = start && ((st_q == ST_IDLE) || (st_q == ST_FIN));
  assign waiting  = (st_q == ST_WCMD) || (st_q == ST_WDAT);
  assign bit_mask = (st_q == ST_WDAT) ? (32'd1 << BIT_DATA_RDY) : (32'd1 << BIT_CMD_DONE);
  assign hit      = waiting && ((sts_in & bit_mask) != 32'd0);

  mmc_boot_poll #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk(clk), .rst_n(rst_i_n), .active(waiting), .hit(hit), .expired(tmo)
  );

  mmc_boot_xfer #(.AW(AW), .BCW(BCW), .WORDS(WORDS)) u_xfer (
    .clk(clk), .rst_n(rst_i_n), .load(accept), .first_blk(first_blk),
    .blk_cnt(blk_cnt), .base(mem_base), .adv(st_q == ST_DATA),
    .blk_num(blk_num), .addr(mem_addr), .last_word(last_word),
    .last_blk(last_blk), .none_left(none_left)
  );

  // next-state logic
  always_comb begin
    st_d     = st_q;
    step_d   = step_q;
    set_done = 1'b0;
    set_err  = 1'b0;
    fast_set = 1'b0;
    case (st_q)
      ST_IDLE:  if (accept) st_d = ST_INIT;
      ST_INIT:  begin st_d = ST_CLR; step_d = STEP_GO_IDLE; end
      ST_CLR:   st_d = ST_ISSUE;
      ST_ISSUE: st_d = ST_WCMD;
      ST_WCMD:  if (hit || tmo) st_d = ST_NEXT;
      ST_NEXT: begin
        st_d = ST_CLR;
        case (step_q)
          STEP_GO_IDLE: step_d = STEP_OP_COND;
          STEP_OP_COND: if (resp0[31]) step_d = STEP_ALL_CID;
          STEP_ALL_CID: step_d = STEP_SET_RCA;
          STEP_SET_RCA: begin step_d = STEP_GET_CSD; fast_set = 1'b1; end
          STEP_GET_CSD: step_d = STEP_SELECT;
          STEP_SELECT:  step_d = STEP_BLKLEN;
          STEP_BLKLEN:  if (none_left) begin st_d = ST_FIN; set_done = 1'b1; end
                        else step_d = STEP_STATUS;
          STEP_STATUS:  if (resp0 == STATUS_OK) step_d = STEP_READ;
                        else begin st_d = ST_FIN; set_err = 1'b1; end
          STEP_READ:    st_d = ST_WDAT;
          default:      st_d = ST_IDLE;
        endcase
      end
      ST_WDAT: begin
        if (hit) st_d = ST_DATA;
        else if (tmo) begin st_d = ST_FIN; set_err = 1'b1; end
      end
      ST_DATA: begin
        if (last_word) begin
          if (last_blk) begin st_d = ST_FIN; set_done = 1'b1; end
          else begin st_d = ST_CLR; step_d = STEP_STATUS; end
        end
      end
      ST_FIN:  if (accept) st_d = ST_INIT;
      default: st_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q     <= ST_IDLE;
      step_q   <= STEP_GO_IDLE;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      cfg_on_q <= 1'b0;
      fast_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
      if (accept) begin
        done_q <= 1'b0;
        err_q  <= 1'b0;
      end else begin
        if (set_done) done_q <= 1'b1;
        if (set_err)  err_q  <= 1'b1;
      end
      if (st_q == ST_INIT) cfg_on_q <= 1'b1;
      if (st_q == ST_INIT)  fast_q <= 1'b0;
      else if (fast_set)    fast_q <= 1'b1;
    end
  end

  always_comb begin
    case (step_q)
      STEP_OP_COND:  cmd_arg = OCR_ARG;
      STEP_SET_RCA,
      STEP_GET_CSD,
      STEP_SELECT,
      STEP_STATUS:   cmd_arg = ADDR_ARG;
      STEP_BLKLEN:   cmd_arg = 32'(BLK_BYTES);
      STEP_READ:     cmd_arg = blk_num << SHIFT;
      default:       cmd_arg = 32'd0;
    endcase
  end

  assign cmd_word      = step_word(step_q);
  assign cmd_start     = (st_q == ST_ISSUE);
  assign sts_wr        = (st_q == ST_CLR) || hit;
  assign sts_wdata     = (st_q == ST_CLR) ? 32'd0 : (sts_in & ~bit_mask);
  assign dat_rd        = (st_q == ST_DATA);
  assign mem_we        = (st_q == ST_DATA);
  assign mem_wdata     = dat_in;
  assign cfg_soft_rst  = (st_q == ST_INIT);
  assign cfg_byte_swap = cfg_on_q;
  assign cfg_clk_en    = cfg_on_q;
  assign cfg_blk_size  = cfg_on_q ? 16'(BLK_BYTES) : 16'd0;
  assign cfg_clk_div   = fast_q ? DIV_FAST : DIV_SLOW;
  assign done          = done_q;
  assign error         = err_q;
endmodule

// File: rtl/mmc_boot_chk.sv
module mmc_boot_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          cmd_start,
  input logic [31:0]   cmd_word,
  input logic [3:0]    cfg_clk_div,
  input logic          cfg_clk_en,
  input logic          cfg_byte_swap,
  input logic [31:0]   sts_in,
  input logic          sts_wr,
  input logic [31:0]   sts_wdata,
  input logic          dat_rd,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          done,
  input logic          error
);
  p_clear_before_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |-> $past(sts_wr && (sts_wdata == 32'd0)));

  p_cfg_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |-> (cfg_clk_en && cfg_byte_swap));

  p_fast_clock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && (cmd_word == 32'h0980_6000)) |-> (cfg_clk_div == 4'd1));

  p_mem_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + AW'(1)));

  p_read_writes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dat_rd |-> mem_we);

  p_clear_one_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && (sts_wdata != 32'd0)) |-> ($countones(sts_in ^ sts_wdata) == 1));

  p_flags_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

  p_flags_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((done || error) && !start) |=> ($stable(done) && $stable(error)));
endmodule

bind mmc_boot_loader mmc_boot_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cmd_start(cmd_start),
  .cmd_word(cmd_word), .cfg_clk_div(cfg_clk_div), .cfg_clk_en(cfg_clk_en),
  .cfg_byte_swap(cfg_byte_swap), .sts_in(sts_in), .sts_wr(sts_wr),
  .sts_wdata(sts_wdata), .dat_rd(dat_rd), .mem_we(mem_we),
  .mem_addr(mem_addr), .done(done), .error(error)
);

// File: tb/sim_mmc_boot_loader.sv
module sim_mmc_boot_loader;
  localparam int AW = 16;
  localparam int BCW = 16;
  localparam int LIM = 50;
  localparam int NW = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic           start = 1'b0;
  logic [31:0]    first_blk = '0;
  logic [BCW-1:0] blk_cnt = '0;
  logic [AW-1:0]  mem_base = '0;
  logic           cfg_soft_rst, cfg_byte_swap, cfg_clk_en;
  logic [15:0]    cfg_blk_size;
  logic [3:0]     cfg_clk_div;
  logic           cmd_start, sts_wr, dat_rd, mem_we, done, error;
  logic [31:0]    cmd_word, cmd_arg, sts_wdata, mem_wdata, dat_in;
  logic [AW-1:0]  mem_addr;
  logic [31:0]    status_q = '0;
  logic [31:0]    resp0_q = '0;

  mmc_boot_loader #(.AW(AW), .BCW(BCW), .BLK_BYTES(512), .POLL_LIMIT(LIM)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .first_blk(first_blk),
    .blk_cnt(blk_cnt), .mem_base(mem_base), .cfg_soft_rst(cfg_soft_rst),
    .cfg_byte_swap(cfg_byte_swap), .cfg_blk_size(cfg_blk_size),
    .cfg_clk_div(cfg_clk_div), .cfg_clk_en(cfg_clk_en), .cmd_start(cmd_start),
    .cmd_word(cmd_word), .cmd_arg(cmd_arg), .sts_in(status_q), .sts_wr(sts_wr),
    .sts_wdata(sts_wdata), .resp0(resp0_q), .dat_rd(dat_rd), .dat_in(dat_in),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .done(done), .error(error)
  );

  int checks = 0;
  int failures = 0;

  // responder configuration
  logic        rsp_reset = 1'b0;
  int          ok_after = 0, fail13 = 999, faildat = 999;
  logic [31:0] drop_word = '0;
  // responder state
  int          cc_cnt, dr_cnt, n1, n13, n17, widx, nlog, nsoft, bad_order, bad_clr, bad_cfg;
  logic        dropped, prev_clear;
  logic [31:0] cur_blk, nxt;
  logic [31:0] lw [512];
  logic [31:0] la [512];
  logic [3:0]  ldiv [512];
  logic [31:0] mem [2048];
  logic [31:0] ew [512];
  logic [31:0] ea [512];
  int          ne;

  function automatic logic [31:0] pat(logic [31:0] b, int k);
    return {b[15:0], 16'(k)} ^ 32'h5A00_0000;
  endfunction

  assign dat_in = pat(cur_blk, widx);

  always @(posedge clk) begin
    if (rsp_reset) begin
      status_q <= '0; resp0_q <= '0; cc_cnt <= 0; dr_cnt <= 0; n1 <= 0; n13 <= 0;
      n17 <= 0; widx <= 0; nlog <= 0; nsoft <= 0; bad_order <= 0; bad_clr <= 0;
      bad_cfg <= 0; dropped <= 1'b0; prev_clear <= 1'b0; cur_blk <= '0;
      for (int i = 0; i < 2048; i++) mem[i] <= 32'hDEAD_BEEF;
    end else begin
      nxt = sts_wr ? sts_wdata : status_q;
      if (sts_wr && sts_wdata != 0) begin
        if (!((status_q[16] && sts_wdata == (status_q & ~(32'd1 << 16))) ||
              (status_q[20] && sts_wdata == (status_q & ~(32'd1 << 20)))))
          bad_clr <= bad_clr + 1;
      end
      if (cc_cnt == 1) nxt = nxt | (32'd1 << 16) | (32'd1 << 5);
      if (dr_cnt == 1) nxt = nxt | (32'd1 << 20) | (32'd1 << 5);
      if (cmd_start) begin
        lw[nlog] <= cmd_word; la[nlog] <= cmd_arg; ldiv[nlog] <= cfg_clk_div;
        nlog <= nlog + 1;
        if (!prev_clear) bad_order <= bad_order + 1;
        if (!(cfg_clk_en && cfg_byte_swap && cfg_blk_size == 16'd512)) bad_cfg <= bad_cfg + 1;
        resp0_q <= 32'd0;
        if (cmd_word == 32'h0140_5040) begin
          resp0_q <= (n1 >= ok_after) ? 32'h80FF_8000 : 32'h00FF_8000;
          n1 <= n1 + 1;
        end
        if (cmd_word == 32'h0d40_0000) begin
          resp0_q <= (n13 == fail13) ? 32'h0000_0B00 : 32'h0000_0900;
          n13 <= n13 + 1;
        end
        if (cmd_word == drop_word && !dropped) begin
          dropped <= 1'b1; cc_cnt <= 0;
        end else cc_cnt <= 3;
        if (cmd_word == 32'h1148_0000) begin
          cur_blk <= cmd_arg >> 9; widx <= 0; n17 <= n17 + 1;
          dr_cnt <= (n17 == faildat) ? 0 : 8;
        end else if (dr_cnt > 0) dr_cnt <= dr_cnt - 1;
      end else begin
        if (cc_cnt > 0) cc_cnt <= cc_cnt - 1;
        if (dr_cnt > 0) dr_cnt <= dr_cnt - 1;
      end
      if (dat_rd) widx <= widx + 1;
      status_q <= nxt;
      prev_clear <= sts_wr && sts_wdata == 32'd0;
      if (cfg_soft_rst) nsoft <= nsoft + 1;
      if (mem_we) mem[mem_addr[10:0]] <= mem_wdata;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w, input logic [31:0] a);
    ew[ne] = w; ea[ne] = a; ne++;
  endtask

  task automatic run_case(input logic [31:0] fb, input int cnt, input int base,
                          input int retries, input int f13, input int fdat,
                          input logic [31:0] dropw);
    int lim, blocks_ok, cyc;
    logic exp_err, ord_ok, div_ok;
    @(negedge clk);
    ok_after = retries; fail13 = f13; faildat = fdat; drop_word = dropw;
    rsp_reset = 1'b1;
    @(negedge clk);
    rsp_reset = 1'b0;
    first_blk = fb; blk_cnt = BCW'(cnt); mem_base = AW'(base); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!done && !error, "R11 start clears flags", {30'd0, done, error}, 32'd0);
    cyc = 0;
    while (!done && !error && cyc < 20000) begin @(negedge clk); cyc++; end
    // expected script
    ne = 0;
    push(32'h0000_0040, 32'd0);
    for (int r = 0; r <= retries; r++) push(32'h0140_5040, 32'h4030_0000);
    push(32'h0280_6040, 32'd0);
    push(32'h0340_0040, 32'h0001_0000);
    push(32'h0980_6000, 32'h0001_0000);
    push(32'h0740_0000, 32'h0001_0000);
    push(32'h1040_0000, 32'd512);
    blocks_ok = 0; exp_err = 1'b0;
    for (int b = 0; b < cnt; b++) begin
      push(32'h0d40_0000, 32'h0001_0000);
      if (b == f13) begin exp_err = 1'b1; break; end
      push(32'h1148_0000, (fb + 32'(b)) << 9);
      if (b == fdat) begin exp_err = 1'b1; break; end
      blocks_ok++;
    end
    chk(done == !exp_err && error == exp_err, "R11/R7/R10 end flags",
        {30'd0, done, error}, {30'd0, !exp_err, exp_err});
    chk(nlog == ne, "R4/R5/R6/R12 command count", 32'(nlog), 32'(ne));
    lim = (nlog < ne) ? nlog : ne;
    ord_ok = 1'b1; div_ok = 1'b1;
    for (int i = 0; i < lim; i++) begin
      if (lw[i] != ew[i] || la[i] != ea[i]) begin
        if (ord_ok) $display("FAIL R4/R6/R8 command %0d actual=0x%08h/0x%08h expected=0x%08h/0x%08h",
                             i, lw[i], la[i], ew[i], ea[i]);
        ord_ok = 1'b0;
      end
      if (ldiv[i] != ((i < retries + 4) ? 4'd7 : 4'd1)) div_ok = 1'b0;
    end
    checks++; if (!ord_ok) failures++;
    chk(div_ok, "R2/R6 clock divider per command", 32'(div_ok), 32'd1);
    chk(nsoft == 1, "R2 single soft reset", 32'(nsoft), 32'd1);
    chk(bad_cfg == 0, "R2 config before commands", 32'(bad_cfg), 32'd0);
    chk(bad_order == 0, "R3 clear precedes issue", 32'(bad_order), 32'd0);
    chk(bad_clr == 0, "R9 single-bit clear", 32'(bad_clr), 32'd0);
    begin
      logic mok; logic [31:0] ev, av; int bad_at;
      mok = 1'b1; bad_at = 0; ev = 0; av = 0;
      for (int a = 0; a < 2048; a++) begin
        logic [31:0] e;
        e = 32'hDEAD_BEEF;
        if (a >= base && a < base + blocks_ok * NW)
          e = pat(fb + 32'((a - base) / NW), (a - base) % NW);
        if (mok && mem[a] != e) begin mok = 1'b0; bad_at = a; ev = e; av = mem[a]; end
      end
      if (!mok) $display("FAIL R8/R12 memory word %0d", bad_at);
      chk(mok, "R8/R10/R12 memory image", av, ev);
    end
    repeat (12) @(negedge clk);
    chk(done == !exp_err && error == exp_err, "R11 flags held",
        {30'd0, done, error}, {30'd0, !exp_err, exp_err});
    chk(nlog == ne, "R12 nothing after end", 32'(nlog), 32'(ne));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rsp_reset = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rsp_reset = 1'b0;
    // R1 reset state
    chk(!done && !error && !cmd_start && !sts_wr && !dat_rd && !mem_we && !cfg_soft_rst && !cfg_clk_en,
        "R1 reset outputs", {24'd0, done, error, cmd_start, sts_wr, dat_rd, mem_we, cfg_soft_rst, cfg_clk_en}, 32'd0);
    // directed cases
    run_case(32'd5, 3, 100, 2, 999, 999, 32'h0);                 // R5 R8 normal
    run_case(32'd9, 0, 0, 0, 999, 999, 32'h0);                   // R11 zero blocks
    run_case(32'd20, 3, 300, 1, 1, 999, 32'h0);                  // R7 R12 status fail
    run_case(32'd40, 2, 500, 0, 999, 0, 32'h0);                  // R10 data timeout
    run_case(32'd7, 1, 900, 0, 999, 999, 32'h0740_0000);         // R10 command timeout continues
    run_case(32'hFFFF_FFFF, 2, 1200, 0, 999, 999, 32'h0);       // R8 block number wrap
    // random cases
    for (int n = 0; n < 5; n++) begin
      int c, b, r, f;
      c = 1 + int'($urandom_range(3, 0));
      b = int'($urandom_range(1000, 0));
      r = int'($urandom_range(4, 0));
      f = ($urandom_range(2, 0) == 0) ? int'($urandom_range(c - 1, 0)) : 999;
      run_case($urandom(), c, b, r, 999, f, 32'h0);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule